// File: doc/BRIEF.md
# ECC-Protected Word Store

This block is a small word store with nonvolatile-style write rules, built from a register array. Each 16-bit user word is stored together with 6 check bits that no port can read or write. The store takes commands through a valid/ready handshake. There are three commands:

- **Erase** returns one word to the all-ones state.
- **Program** writes one to four consecutive words. A program can only clear bits.
- **Read** returns one word after single-error correction and double-error detection.

A program command checks its own result in the next cycle. It compares what the cells now hold with the codeword it meant to store, and grades any mismatch in a two-bit status. Because programming only clears bits, writing a word a second time without an erase can damage its check bits as well as its data. The status and the read flags make that damage visible.

The depth of the array and the width of the address are parameters. An address that falls past the last word is refused. The refusal is reported with an access-error flag, and the array is left untouched.

Top module: `ecc_word_store`

## Requirements
- R1: Out of reset, every word reads back as 16'hFFFF with both error flags low, `cmd_ready` is high, and `rsp_valid` is low.
- R2: An erase (`cmd_op` 2'b10) sets all 22 stored bits of the word at `cmd_addr` to 1, so a later read returns 16'hFFFF with no flag.
- R3: A program (`cmd_op` 2'b11) replaces each stored word with the bitwise AND of its old 22 bits and the new codeword, so no bit ever goes from 0 to 1.
- R4: A read (`cmd_op` 2'b01) whose syndrome equals one code column returns corrected data with `rsp_sec` high. A syndrome equal to one code column means a single flipped data bit or check bit.
- R5: A read whose syndrome is nonzero and matches no column returns `rsp_ded` high and `rsp_sec` low.
- R6: The program status is graded on the word with the most bits that differ from its intended codeword: 2'b00 when no bit differs, 2'b10 when exactly one bit differs, and 2'b11 when more than one differs. The value 2'b01 never occurs.
- R7: A program writes `cmd_cnt`+1 consecutive words starting at `cmd_addr`. Word i is taken from `cmd_wdata[16*i +: 16]`. Words beyond the count are left unchanged.
- R8: If an erase or read has `cmd_addr` ≥ DEPTH, or a program has `cmd_addr`+`cmd_cnt` ≥ DEPTH, the response has `rsp_acc_err` high with zero data, flags and status, and the array is left unchanged.
- R9: A command is accepted on a rising edge with `cmd_valid` and `cmd_ready` both high. At that edge `rsp_status` is cleared and `cmd_ready` drops. The one-cycle `rsp_valid` pulse follows on the second edge after acceptance, and `cmd_ready` returns at that same edge.
- R10: The check code is defined as follows. The column for data bit k is the k-th smallest 6-bit value of weight 3, and the column for check bit j is 1<<j. Stored check bits are the XOR of the columns of the set data bits, XORed with the constant that makes the codeword of 16'hFFFF equal to 6'h3F. The codeword layout is {check, data}.
- R11: Op 2'b00 does nothing to the array and returns an all-zero response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Store can accept a command |
| cmd_op | input | 2 | 00 none, 01 read, 10 erase, 11 program |
| cmd_addr | input | ADDR_W | Word address (first word of a program) |
| cmd_cnt | input | 2 | Program word count minus one |
| cmd_wdata | input | 64 | Program data, word i in bits 16*i+15:16*i |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | 16 | Corrected read data |
| rsp_sec | output | 1 | Single error corrected on read |
| rsp_ded | output | 1 | Uncorrectable error on read |
| rsp_acc_err | output | 1 | Command refused, address out of range |
| rsp_status | output | 2 | Program verify grade, held until next accept |

## Verification
Every command produces exactly one response. That response is due on the second rising edge after the accepting edge, and the bench observes it on the falling edge just after that. The driver records the cycle number at which each expected item becomes due, and the monitor fails any response that arrives at a different count. The cleared status is sampled on the falling edge right after the accept, one cycle before the response. Data, flags and grade come from a shadow array that is updated with the AND rule and decoded with the code defined in R10.

// File: rtl/ecc_store_pkg.sv
package ecc_store_pkg;
  localparam int DATA_W = 16;
  localparam int CHK_W  = 6;
  localparam int CW_W   = DATA_W + CHK_W;
  localparam int BURST  = 4;
  localparam int CNT_W  = $clog2(BURST);

  typedef enum logic [1:0] {
    OP_NOP   = 2'b00,
    OP_READ  = 2'b01,
    OP_ERASE = 2'b10,
    OP_PROG  = 2'b11
  } op_e;

  // k-th smallest 6-bit value with three ones: odd-weight data column
  function automatic logic [CHK_W-1:0] hcol(input int k);
    logic [CHK_W-1:0] r;
    int n;
    r = '0;
    n = 0;
    for (int v = 0; v < 64; v++) begin
      if ($countones(v[CHK_W-1:0]) == 3) begin
        if (n == k) r = v[CHK_W-1:0];
        n++;
      end
    end
    return r;
  endfunction

  function automatic logic [CHK_W-1:0] raw_par(input logic [DATA_W-1:0] d);
    logic [CHK_W-1:0] p;
    p = '0;
    for (int k = 0; k < DATA_W; k++)
      if (d[k]) p = p ^ hcol(k);
    return p;
  endfunction

  // offset so that the all-ones word carries all-ones check bits
  localparam logic [CHK_W-1:0] CHK_OFS = raw_par({DATA_W{1'b1}}) ^ {CHK_W{1'b1}};

  function automatic logic [CHK_W-1:0] chk_of(input logic [DATA_W-1:0] d);
    return raw_par(d) ^ CHK_OFS;
  endfunction
endpackage

// File: rtl/ecc_enc.sv
module ecc_enc
  import ecc_store_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CW_W-1:0]   cw_o
);
  assign cw_o = {chk_of(data_i), data_i};
endmodule

// File: rtl/ecc_dec.sv
module ecc_dec
  import ecc_store_pkg::*;
(
  input  logic [CW_W-1:0]   cw_i,
  output logic [DATA_W-1:0] data_o,
  output logic              sec_o,
  output logic              ded_o
);
  logic [CHK_W-1:0]  syn;
  logic [DATA_W-1:0] flip;

  always_comb begin
    syn = cw_i[CW_W-1:DATA_W] ^ chk_of(cw_i[DATA_W-1:0]);
    for (int k = 0; k < DATA_W; k++)
      flip[k] = (syn == hcol(k));
    data_o = cw_i[DATA_W-1:0] ^ flip;
    sec_o  = (syn != '0) && ((|flip) || ($countones(syn) == 1));
    ded_o  = (syn != '0) && !sec_o;
  end
endmodule

// File: rtl/ecc_cell_array.sv
module ecc_cell_array
  import ecc_store_pkg::*;
#(
  parameter int DEPTH  = 20,
  parameter int ADDR_W = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       erase_en,
  input  logic                       prog_en,
  input  logic [ADDR_W-1:0]          base,
  input  logic [CNT_W-1:0]           cnt,
  input  logic [BURST-1:0][CW_W-1:0] cw_in,
  output logic [BURST-1:0][CW_W-1:0] rd_cw
);
  localparam int IW = ADDR_W + 1;

  logic [CW_W-1:0] cells [DEPTH];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic [CW_W-1:0] mem_q, mem_d;
    logic [IW-1:0]   off;
    logic            wr_en;

    always_comb begin
      off   = IW'(w) - {1'b0, base};
      mem_d = mem_q;
      wr_en = 1'b0;
      if (erase_en && off == '0) begin
        mem_d = '1;
        wr_en = 1'b1;
      end else if (prog_en && off <= IW'(cnt)) begin
        mem_d = mem_q & cw_in[off[CNT_W-1:0]];
        wr_en = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mem_q <= '1;
      else if (wr_en) mem_q <= mem_d;
    end

    assign cells[w] = mem_q;
  end

  for (genvar i = 0; i < BURST; i++) begin : g_rd
    logic [IW-1:0] idx;
    always_comb begin
      idx      = {1'b0, base} + IW'(i);
      rd_cw[i] = (idx < IW'(DEPTH)) ? cells[idx[ADDR_W-1:0]] : '1;
    end
  end
endmodule

// File: rtl/ecc_word_store.sv
module ecc_word_store
  import ecc_store_pkg::*;
#(
  parameter int DEPTH  = 20,
  parameter int ADDR_W = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid,
  output logic                    cmd_ready,
  input  logic [1:0]              cmd_op,
  input  logic [ADDR_W-1:0]       cmd_addr,
  input  logic [CNT_W-1:0]        cmd_cnt,
  input  logic [BURST*DATA_W-1:0] cmd_wdata,
  output logic                    rsp_valid,
  output logic [DATA_W-1:0]       rsp_rdata,
  output logic                    rsp_sec,
  output logic                    rsp_ded,
  output logic                    rsp_acc_err,
  output logic [1:0]              rsp_status
);
  localparam int IW = ADDR_W + 1;

  // command hold registers
  logic                          busy_q, busy_d;
  op_e                           op_q, op_d;
  logic [ADDR_W-1:0]             addr_q, addr_d;
  logic [CNT_W-1:0]              cnt_q, cnt_d;
  logic [BURST-1:0][DATA_W-1:0]  wdata_q, wdata_d;
  logic                          err_q, err_d;
  // response registers
  logic                          vld_q, vld_d;
  logic [DATA_W-1:0]             rdata_q, rdata_d;
  logic                          sec_q, sec_d, ded_q, ded_d, aerr_q, aerr_d;
  logic [1:0]                    stat_q, stat_d;

  logic                          accept, oob;
  op_e                           op_in;
  logic [IW-1:0]                 last;
  logic [BURST-1:0][DATA_W-1:0]  cmd_words, enc_in;
  logic [BURST-1:0][CW_W-1:0]    enc_cw, rd_cw;
  logic [ADDR_W-1:0]             arr_base;
  logic                          erase_en, prog_en;
  logic [DATA_W-1:0]             dec_data;
  logic                          dec_sec, dec_ded;
  logic [1:0]                    grade;

  assign cmd_ready = !busy_q;
  assign accept    = cmd_valid && cmd_ready;
  assign op_in     = op_e'(cmd_op);
  assign cmd_words = cmd_wdata;

  always_comb begin
    last = {1'b0, cmd_addr} + ((op_in == OP_PROG) ? IW'(cmd_cnt) : '0);
    oob  = (op_in != OP_NOP) && (last >= IW'(DEPTH));
  end

  // encoders serve the write at accept and the verify one cycle later
  assign enc_in = busy_q ? wdata_q : cmd_words;
  for (genvar i = 0; i < BURST; i++) begin : g_enc
    ecc_enc u_enc (.data_i(enc_in[i]), .cw_o(enc_cw[i]));
  end

  assign arr_base = busy_q ? addr_q : cmd_addr;
  assign erase_en = accept && (op_in == OP_ERASE) && !oob;
  assign prog_en  = accept && (op_in == OP_PROG)  && !oob;

  ecc_cell_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_array (
    .clk(clk), .rst_n(rst_n), .erase_en(erase_en), .prog_en(prog_en),
    .base(arr_base), .cnt(cmd_cnt), .cw_in(enc_cw), .rd_cw(rd_cw)
  );

  ecc_dec u_dec (.cw_i(rd_cw[0]), .data_o(dec_data), .sec_o(dec_sec), .ded_o(dec_ded));

  // post-program verify: worst word decides the grade
  always_comb begin
    grade = 2'b00;
    for (int i = 0; i < BURST; i++) begin
      if ((CNT_W+1)'(i) <= {1'b0, cnt_q}) begin
        if ($countones(rd_cw[i] ^ enc_cw[i]) > 1)
          grade = 2'b11;
        else if ($countones(rd_cw[i] ^ enc_cw[i]) == 1 && grade == 2'b00)
          grade = 2'b10;
      end
    end
  end

  // next state
  always_comb begin
    busy_d  = busy_q;
    op_d    = op_q;
    addr_d  = addr_q;
    cnt_d   = cnt_q;
    wdata_d = wdata_q;
    err_d   = err_q;
    vld_d   = busy_q;
    rdata_d = rdata_q;
    sec_d   = sec_q;
    ded_d   = ded_q;
    aerr_d  = aerr_q;
    stat_d  = stat_q;
    if (accept) begin
      busy_d  = 1'b1;
      op_d    = op_in;
      addr_d  = cmd_addr;
      cnt_d   = cmd_cnt;
      wdata_d = cmd_words;
      err_d   = oob;
      stat_d  = 2'b00;
    end else if (busy_q) begin
      busy_d  = 1'b0;
      rdata_d = (op_q == OP_READ && !err_q) ? dec_data : '0;
      sec_d   = (op_q == OP_READ && !err_q) && dec_sec;
      ded_d   = (op_q == OP_READ && !err_q) && dec_ded;
      aerr_d  = err_q;
      stat_d  = (op_q == OP_PROG && !err_q) ? grade : 2'b00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      op_q    <= OP_NOP;
      addr_q  <= '0;
      cnt_q   <= '0;
      wdata_q <= '0;
      err_q   <= 1'b0;
      vld_q   <= 1'b0;
      rdata_q <= '0;
      sec_q   <= 1'b0;
      ded_q   <= 1'b0;
      aerr_q  <= 1'b0;
      stat_q  <= 2'b00;
    end else begin
      busy_q  <= busy_d;
      op_q    <= op_d;
      addr_q  <= addr_d;
      cnt_q   <= cnt_d;
      wdata_q <= wdata_d;
      err_q   <= err_d;
      vld_q   <= vld_d;
      rdata_q <= rdata_d;
      sec_q   <= sec_d;
      ded_q   <= ded_d;
      aerr_q  <= aerr_d;
      stat_q  <= stat_d;
    end
  end

  assign rsp_valid   = vld_q;
  assign rsp_rdata   = rdata_q;
  assign rsp_sec     = sec_q;
  assign rsp_ded     = ded_q;
  assign rsp_acc_err = aerr_q;
  assign rsp_status  = stat_q;
endmodule

// File: rtl/ecc_word_store_chk.sv
module ecc_word_store_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic       rsp_valid,
  input logic       rsp_sec,
  input logic       rsp_ded,
  input logic       rsp_acc_err,
  input logic [1:0] rsp_status
);
  assert_ready_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  assert_rsp_due_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> ##1 rsp_valid);

  assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_status_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (rsp_status == 2'b00));

  assert_status_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_status != 2'b01);

  assert_flags_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_sec && rsp_ded));

  assert_err_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_acc_err) |-> (!rsp_sec && !rsp_ded && rsp_status == 2'b00));
endmodule

bind ecc_word_store ecc_word_store_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .rsp_valid(rsp_valid), .rsp_sec(rsp_sec), .rsp_ded(rsp_ded),
  .rsp_acc_err(rsp_acc_err), .rsp_status(rsp_status)
);

// File: tb/ecc_word_store_tb.sv
module ecc_word_store_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 20;
  localparam int ADDR_W = 5;

  logic clk, rst_n, cmd_valid, cmd_ready, rsp_valid, rsp_sec, rsp_ded, rsp_acc_err;
  logic [1:0] cmd_op, cmd_cnt, rsp_status;
  logic [ADDR_W-1:0] cmd_addr;
  logic [63:0] cmd_wdata;
  logic [15:0] rsp_rdata;

  ecc_word_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_cnt(cmd_cnt), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_sec(rsp_sec), .rsp_ded(rsp_ded),
    .rsp_acc_err(rsp_acc_err), .rsp_status(rsp_status)
  );

  typedef struct {
    logic [15:0] rdata;
    logic        sec, ded, aerr;
    logic [1:0]  stat;
    int          due;
  } exp_t;

  exp_t  expq[$];
  string tagq[$];
  int checks = 0, bad = 0, cyc = 0;
  logic [21:0] shadow [DEPTH];

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  // code model taken from R10
  function automatic logic [5:0] bcol(input int k);
    logic [5:0] r; int n;
    r = '0; n = 0;
    for (int v = 0; v < 64; v++)
      if ($countones(v[5:0]) == 3) begin
        if (n == k) r = v[5:0];
        n++;
      end
    return r;
  endfunction

  function automatic logic [5:0] bpar(input logic [15:0] d);
    logic [5:0] p; p = '0;
    for (int k = 0; k < 16; k++) if (d[k]) p ^= bcol(k);
    return p;
  endfunction

  function automatic logic [21:0] bcw(input logic [15:0] d);
    return {bpar(d) ^ bpar(16'hFFFF) ^ 6'h3F, d};
  endfunction

  task automatic fail(input string tag, input string what, input int act, input int expv);
    bad++;
    $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
  endtask

  task automatic issue(input logic [1:0] op, input int addr, input int cnt,
                       input logic [63:0] wd, input string tag);
    exp_t e;
    int last;
    e.rdata = '0; e.sec = 0; e.ded = 0; e.aerr = 0; e.stat = 2'b00;
    last = addr + ((op == 2'b11) ? cnt : 0);
    if (op != 2'b00 && last >= DEPTH) e.aerr = 1;
    else if (op == 2'b01) begin
      logic [21:0] s; logic [5:0] syn; logic [15:0] d;
      s = shadow[addr];
      syn = s[21:16] ^ bcw(s[15:0]) >> 16;
      d = s[15:0];
      if (syn != 0) begin
        for (int k = 0; k < 16; k++)
          if (syn == bcol(k)) begin d[k] = ~d[k]; e.sec = 1; end
        if ($countones(syn) == 1) e.sec = 1;
        e.ded = !e.sec;
      end
      e.rdata = d;
    end else if (op == 2'b10) shadow[addr] = '1;
    else if (op == 2'b11) begin
      for (int i = 0; i <= cnt; i++) begin
        logic [21:0] c; int pc;
        c = bcw(wd[16*i +: 16]);
        shadow[addr+i] = shadow[addr+i] & c;
        pc = $countones(shadow[addr+i] ^ c);
        if (pc > 1) e.stat = 2'b11;
        else if (pc == 1 && e.stat == 2'b00) e.stat = 2'b10;
      end
    end
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_addr = ADDR_W'(addr); cmd_cnt = 2'(cnt); cmd_wdata = wd;
    e.due = cyc + 2;
    expq.push_back(e); tagq.push_back(tag);
    @(negedge clk);
    cmd_valid = 0;
    checks++;
    if (rsp_status !== 2'b00) fail("R9", "status not cleared", rsp_status, 0);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      checks++;
      if (expq.size() == 0) fail("R9", "unexpected response", 1, 0);
      else begin
        exp_t e; string t;
        e = expq.pop_front(); t = tagq.pop_front();
        if (cyc != e.due) fail(t, "response cycle", cyc, e.due);
        else if (rsp_rdata !== e.rdata) fail(t, "rdata", rsp_rdata, e.rdata);
        else if (rsp_sec !== e.sec) fail(t, "sec", rsp_sec, e.sec);
        else if (rsp_ded !== e.ded) fail(t, "ded", rsp_ded, e.ded);
        else if (rsp_acc_err !== e.aerr) fail(t, "acc_err", rsp_acc_err, e.aerr);
        else if (rsp_status !== e.stat) fail(t, "status", rsp_status, e.stat);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fail("R9", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", checks + 1, bad);
    $finish;
  end

  initial begin
    logic [15:0] sx, sy, dx, dy;
    int found1, found2;
    for (int a = 0; a < DEPTH; a++) shadow[a] = '1;
    rst_n = 0; cmd_valid = 0; cmd_op = 0; cmd_addr = 0; cmd_cnt = 0; cmd_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    checks++; if (cmd_ready !== 1) fail("R1", "ready after reset", cmd_ready, 1);
    checks++; if (rsp_valid !== 0) fail("R1", "rsp_valid after reset", rsp_valid, 0);
    checks++; if (rsp_status !== 0) fail("R1", "status after reset", rsp_status, 0);

    // find rewrite pairs whose damage is one bit and two bits
    found1 = 0; found2 = 0; sx = 0; sy = 0; dx = 0; dy = 0;
    for (int x = 0; x < 512; x++)
      for (int k = 0; k < 16; k++) begin
        logic [15:0] xv, yv; int pc;
        xv = 16'(x * 97); yv = xv | (16'h1 << k);
        if (xv != yv) begin
          pc = $countones((bcw(xv) & bcw(yv)) ^ bcw(yv));
          if (pc == 1 && found1 == 0) begin sx = xv; sy = yv; found1 = 1; end
          if (pc == 2 && found2 == 0) begin dx = xv; dy = yv; found2 = 1; end
        end
      end

    issue(2'b01, 0, 0, 0, "R1");
    issue(2'b01, DEPTH-1, 0, 0, "R1");
    issue(2'b10, 3, 0, 0, "R2");
    issue(2'b11, 3, 0, 64'h1234, "R3");
    issue(2'b01, 3, 0, 0, "R3");
    issue(2'b11, 3, 0, 64'h1234, "R3");
    issue(2'b11, 3, 0, 64'hEDCB, "R6");
    issue(2'b01, 3, 0, 0, "R3");
    issue(2'b10, 3, 0, 0, "R2");
    issue(2'b01, 3, 0, 0, "R2");
    issue(2'b11, 5, 0, {48'h0, sx}, "R4");
    issue(2'b11, 5, 0, {48'h0, sy}, "R6");
    issue(2'b01, 5, 0, 0, "R4");
    issue(2'b11, 6, 0, {48'h0, dx}, "R5");
    issue(2'b11, 6, 0, {48'h0, dy}, "R6");
    issue(2'b01, 6, 0, 0, "R5");
    issue(2'b11, 8, 3, 64'hA5A5_0F0F_3C3C_8001, "R7");
    for (int a = 8; a < 12; a++) issue(2'b01, a, 0, 0, "R7");
    issue(2'b11, 12, 1, 64'h1111_2222_3333_4444, "R7");
    issue(2'b01, 13, 0, 0, "R7");
    issue(2'b01, 14, 0, 0, "R7");
    issue(2'b11, 18, 3, 64'h0, "R8");
    issue(2'b01, 18, 0, 0, "R8");
    issue(2'b01, 19, 0, 0, "R8");
    issue(2'b10, 20, 0, 0, "R8");
    issue(2'b01, 31, 0, 0, "R8");
    issue(2'b11, 17, 2, 64'h0000_7777_8888_9999, "R8");
    issue(2'b01, 19, 0, 0, "R8");
    issue(2'b00, 2, 0, 64'h0, "R11");
    issue(2'b01, 2, 0, 0, "R11");
    repeat (4) @(negedge clk);
    checks++;
    if (expq.size() != 0) fail("R9", "missing responses", expq.size(), 0);
    checks++;
    if (found1 == 0 || found2 == 0) fail("R10", "rewrite pair search", found1 + found2, 2);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule